// File: doc/BRIEF.md
# Configuration Space Register File for a Network-Class Function

This block holds the 256-byte configuration space of a single network-class function. A bus front end, which is not part of this block, turns each configuration cycle into one request. The request carries a byte address, a length of 1, 2 or 4 bytes, a direction and up to four data bytes. The block applies a fixed write policy to each byte on its own. It assembles read data little-endian and returns it one cycle after the request.

The identity bytes, the class code and the default register values load at reset. The I/O base register and the expansion-ROM base register are exported already assembled into 32-bit values. The ROM enable bit is exported as well. Two one-cycle pulses tell the address-decode logic outside the block when either base has to be re-evaluated. A parameter selects whether an expansion ROM exists. A second parameter gives its size as a power of two, and that size sets how many low ROM base bits read back as zero.

Top module: `cfg_space_regfile`

## Requirements
- R1: After reset, bytes 0x00..0x01 hold VENDOR_ID and bytes 0x02..0x03 hold DEVICE_ID, both little-endian. Byte 0x04 = 0x01, 0x08 = 0x01, 0x0B = 0x02, 0x0D = 0x20, 0x20 = 0x01, 0x3D = 0x01 (pin A), 0x6A = 0x01 and 0xC1 = 0x20. Every other byte is 0x00. After reset rdata_o, io_base_o, rom_base_o, rom_en_o, io_chg_o and rom_chg_o are all zero.
- R2: A read (req_i=1, we_i=0) of len_i bytes (1, 2 or 4) at addr_i places byte addr_i+i at bits 8i+7..8i. Bytes at or beyond len_i read as zero. Addresses wrap modulo 256. rdata_o is registered: it shows the result in the cycle after the request and holds it until the next read.
- R3: A write whose start address lies in 0x10..0x1F or 0x24..0x2F changes no byte at all, even bytes it spans outside those ranges. It raises no change pulse.
- R4: At byte 0x04 only bit 0 takes the written value. Bits 7..1 are stored as zero.
- R5: A write to byte 0x20 stores (value AND 0xFC) OR 0x01. Bytes 0x21..0x23 store the value unchanged. io_base_o is the 32-bit value of bytes 0x20..0x23 with bits 1..0 cleared. io_chg_o pulses for exactly the cycle after a write in which at least one of these bytes changed, and it does not pulse when all of them keep their old value.
- R6: The interrupt line byte 0x3C is fully writable. The interrupt pin byte 0x3D is read-only.
- R7: With a ROM present, byte 0x30 keeps only bit 0, byte 0x31 keeps bits 7..2, and bytes 0x32..0x33 are fully writable. rom_chg_o pulses in the cycle after any write that touches 0x30..0x33, whether or not a value changed. rom_en_o follows bit 0 of byte 0x30.
- R8: With a ROM of 2^ROM_AW bytes, bits ROM_AW-1..1 of the ROM base dword at 0x30..0x33 read as zero. rom_base_o is that dword with bits ROM_AW-1..0 cleared.
- R9: Without a ROM, bytes 0x30..0x33 are read-only zero. rom_chg_o, rom_en_o and rom_base_o stay zero.
- R10: Every byte not named in R4..R7 keeps its old value on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Start byte address |
| len_i | input | 3 | Access length in bytes: 1, 2 or 4 |
| wdata_i | input | 32 | Write data, byte i goes to addr_i+i |
| rdata_o | output | 32 | Registered read data |
| io_chg_o | output | 1 | One-cycle pulse: I/O base changed |
| rom_chg_o | output | 1 | One-cycle pulse: ROM base register written |
| rom_en_o | output | 1 | Expansion ROM enable bit |
| io_base_o | output | 32 | I/O base address, space bits cleared |
| rom_base_o | output | 32 | ROM base address, size bits cleared |

## Verification
Stored bytes, io_base_o, rom_base_o, rom_en_o and both change pulses all take their new values at the clock edge that ends the request cycle. rdata_o changes at that same edge for a read. The bench drives each request on a falling edge and removes it on the next falling edge. It samples at that point, so each result is read one cycle after its request and the single-cycle pulses are still high. A second check one cycle later confirms that each pulse has cleared. Every write in the vector table is followed by a read-back, so the effect of each policy shows through rdata_o and does not depend on internal state.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  localparam int unsigned CFG_BYTES = 256;
  localparam int unsigned LANES     = 4;

  localparam logic [7:0] OFS_CMD     = 8'h04;
  localparam logic [7:0] OFS_REV     = 8'h08;
  localparam logic [7:0] OFS_CLASS   = 8'h0B;
  localparam logic [7:0] OFS_LAT     = 8'h0D;
  localparam logic [7:0] OFS_IOBAR   = 8'h20;
  localparam logic [7:0] OFS_ROMBAR  = 8'h30;
  localparam logic [7:0] OFS_IRQLINE = 8'h3C;
  localparam logic [7:0] OFS_IRQPIN  = 8'h3D;
  localparam logic [7:0] OFS_CLKCTL  = 8'h6A;
  localparam logic [7:0] OFS_ROUTE   = 8'hC1;

  function automatic logic [7:0] reset_val(input logic [7:0] a,
                                           input logic [15:0] vid,
                                           input logic [15:0] did);
    case (a)
      8'h00:      return vid[7:0];
      8'h01:      return vid[15:8];
      8'h02:      return did[7:0];
      8'h03:      return did[15:8];
      OFS_CMD:    return 8'h01;
      OFS_REV:    return 8'h01;
      OFS_CLASS:  return 8'h02;
      OFS_LAT:    return 8'h20;
      OFS_IOBAR:  return 8'h01;
      OFS_IRQPIN: return 8'h01;
      OFS_CLKCTL: return 8'h01;
      OFS_ROUTE:  return 8'h20;
      default:    return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_wr_policy.sv
module cfg_wr_policy
  import cfg_space_pkg::*;
#(
  parameter bit ROM_PRESENT = 1'b1
) (
  input  logic [7:0] addr_i,
  input  logic [7:0] old_i,
  input  logic [7:0] new_i,
  output logic [7:0] val_o,
  output logic       io_o,
  output logic       rom_o
);
  logic is_io, is_rom;

  assign is_io  = (addr_i[7:2] == OFS_IOBAR[7:2]);
  assign is_rom = ROM_PRESENT && (addr_i[7:2] == OFS_ROMBAR[7:2]);

  always_comb begin
    val_o = old_i;
    if (addr_i == OFS_CMD)            val_o = new_i & 8'h01;
    else if (addr_i == OFS_IOBAR)     val_o = (new_i & 8'hFC) | 8'h01;
    else if (is_io)                   val_o = new_i;
    else if (addr_i == OFS_IRQLINE)   val_o = new_i;
    else if (is_rom) begin
      case (addr_i[1:0])
        2'd0:    val_o = new_i & 8'h01;
        2'd1:    val_o = new_i & 8'hFC;
        default: val_o = new_i;
      endcase
    end
  end

  assign io_o  = is_io;
  assign rom_o = is_rom;
endmodule

// File: rtl/cfg_byte_array.sv
module cfg_byte_array
  import cfg_space_pkg::*;
#(
  parameter int unsigned NBYTES    = CFG_BYTES,
  parameter int unsigned NLANES    = LANES,
  parameter logic [15:0] VENDOR_ID = 16'h1D5A,
  parameter logic [15:0] DEVICE_ID = 16'h0042
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NLANES-1:0]         we_i,
  input  logic [$clog2(NBYTES)-1:0] waddr_i [NLANES],
  input  logic [7:0]                wdata_i [NLANES],
  output logic [7:0]                bytes_o [NBYTES]
);
  localparam int unsigned AW = $clog2(NBYTES);

  logic [7:0] mem_q [NBYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NBYTES; j++)
        mem_q[j] <= reset_val(8'(j), VENDOR_ID, DEVICE_ID);
    end else begin
      for (int j = 0; j < NBYTES; j++)
        for (int k = 0; k < NLANES; k++)
          if (we_i[k] && waddr_i[k] == AW'(j)) mem_q[j] <= wdata_i[k];
    end
  end

  assign bytes_o = mem_q;
endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1D5A,
  parameter logic [15:0] DEVICE_ID   = 16'h0042,
  parameter bit          ROM_PRESENT = 1'b1,
  parameter int unsigned ROM_AW      = 11
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [2:0]  len_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        io_chg_o,
  output logic        rom_chg_o,
  output logic        rom_en_o,
  output logic [31:0] io_base_o,
  output logic [31:0] rom_base_o
);
  localparam logic [31:0] ROM_SZ_MASK = (32'd1 << ROM_AW) - 32'd1;
  localparam logic [31:0] ROM_RD_MASK = ~ROM_SZ_MASK | 32'd1;

  logic [7:0]       bytes   [CFG_BYTES];
  logic [7:0]       ln_addr [LANES];
  logic [7:0]       ln_old  [LANES];
  logic [7:0]       ln_val  [LANES];
  logic [7:0]       ln_rd   [LANES];
  logic [LANES-1:0] ln_act, ln_we, ln_io, ln_rom;
  logic             drop, wr, rd;
  logic [31:0]      rd_word, rom_dw;

  assign drop = (addr_i[7:4] == 4'h1) || (addr_i >= 8'h24 && addr_i <= 8'h2F);
  assign wr   = req_i && we_i && !drop;
  assign rd   = req_i && !we_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign ln_addr[k] = addr_i + 8'(k);
    assign ln_act[k]  = (3'(k) < len_i);
    assign ln_old[k]  = bytes[ln_addr[k]];
    assign ln_we[k]   = wr && ln_act[k];

    cfg_wr_policy #(.ROM_PRESENT(ROM_PRESENT)) u_pol (
      .addr_i (ln_addr[k]),
      .old_i  (ln_old[k]),
      .new_i  (wdata_i[8*k +: 8]),
      .val_o  (ln_val[k]),
      .io_o   (ln_io[k]),
      .rom_o  (ln_rom[k])
    );

    // ROM size bits read back as zero
    always_comb begin
      ln_rd[k] = ln_old[k];
      if (ln_rom[k]) ln_rd[k] = ln_old[k] & ROM_RD_MASK[8*ln_addr[k][1:0] +: 8];
      if (!ln_act[k]) ln_rd[k] = 8'h00;
    end
    assign rd_word[8*k +: 8] = ln_rd[k];
  end

  cfg_byte_array #(
    .NBYTES    (CFG_BYTES),
    .NLANES    (LANES),
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ln_we),
    .waddr_i (ln_addr),
    .wdata_i (ln_val),
    .bytes_o (bytes)
  );

  logic io_diff;
  always_comb begin
    io_diff = 1'b0;
    for (int k = 0; k < LANES; k++)
      if (ln_we[k] && ln_io[k] && ln_val[k] != ln_old[k]) io_diff = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      io_chg_o  <= 1'b0;
      rom_chg_o <= 1'b0;
    end else begin
      if (rd) rdata_o <= rd_word;
      io_chg_o  <= io_diff;
      rom_chg_o <= |(ln_we & ln_rom);
    end
  end

  assign rom_dw     = {bytes[OFS_ROMBAR+8'd3], bytes[OFS_ROMBAR+8'd2],
                       bytes[OFS_ROMBAR+8'd1], bytes[OFS_ROMBAR]};
  assign io_base_o  = {bytes[OFS_IOBAR+8'd3], bytes[OFS_IOBAR+8'd2],
                       bytes[OFS_IOBAR+8'd1], bytes[OFS_IOBAR][7:2], 2'b00};
  assign rom_base_o = ROM_PRESENT ? (rom_dw & ~ROM_SZ_MASK) : 32'd0;
  assign rom_en_o   = ROM_PRESENT && rom_dw[0];

  // Assertions
  p_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && drop) |=> (!io_chg_o && !rom_chg_o && $stable(io_base_o)));

  p_cmd_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bytes[OFS_CMD][7:1] == 7'd0);

  p_io_space_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bytes[OFS_IOBAR][1:0] == 2'b01);

  p_io_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_chg_o |-> $past(req_i && we_i));

  p_io_base_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(io_base_o) |-> io_chg_o);

  p_rom_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_chg_o |-> $past(req_i && we_i));

  p_rom_ro_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ROM_PRESENT || (rom_dw == 32'd0 && !rom_chg_o));
endmodule

// File: tb/cfg_space_regfile_tb.sv
module cfg_space_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VID = 16'h1D5A;
  localparam logic [15:0] DID = 16'h0042;
  localparam int NVEC = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [2:0]  len = 3'd1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, io_base, rom_base, rdata_nr, io_base_nr, rom_base_nr;
  logic        io_chg, rom_chg, rom_en, io_chg_nr, rom_chg_nr, rom_en_nr;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_space_regfile #(.VENDOR_ID(VID), .DEVICE_ID(DID), .ROM_PRESENT(1'b1), .ROM_AW(11)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .len_i(len),
    .wdata_i(wdata), .rdata_o(rdata), .io_chg_o(io_chg), .rom_chg_o(rom_chg),
    .rom_en_o(rom_en), .io_base_o(io_base), .rom_base_o(rom_base));

  cfg_space_regfile #(.VENDOR_ID(VID), .DEVICE_ID(DID), .ROM_PRESENT(1'b0), .ROM_AW(11)) u_dut_nr (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .len_i(len),
    .wdata_i(wdata), .rdata_o(rdata_nr), .io_chg_o(io_chg_nr), .rom_chg_o(rom_chg_nr),
    .rom_en_o(rom_en_nr), .io_base_o(io_base_nr), .rom_base_o(rom_base_nr));

  // wa, wl, wd, ra, rl, expected read, expected io pulse, expected rom pulse
  localparam logic [87:0] VEC [NVEC] = '{
    {8'h04, 3'd1, 32'h000000FE, 8'h04, 3'd4, 32'h00000000, 1'b0, 1'b0}, // R4
    {8'h04, 3'd1, 32'h00000003, 8'h04, 3'd1, 32'h00000001, 1'b0, 1'b0}, // R4
    {8'h20, 3'd4, 32'h0000C0FF, 8'h20, 3'd4, 32'h0000C0FD, 1'b1, 1'b0}, // R5
    {8'h20, 3'd4, 32'h0000C0FF, 8'h20, 3'd4, 32'h0000C0FD, 1'b0, 1'b0}, // R5 same value
    {8'h1E, 3'd4, 32'h12345678, 8'h20, 3'd4, 32'h0000C0FD, 1'b0, 1'b0}, // R3 spans 0x20
    {8'h24, 3'd1, 32'h000000AA, 8'h24, 3'd1, 32'h00000000, 1'b0, 1'b0}, // R3
    {8'h3C, 3'd2, 32'h00005577, 8'h3C, 3'd2, 32'h00000177, 1'b0, 1'b0}, // R6
    {8'h30, 3'd4, 32'hFFFFFFFF, 8'h30, 3'd4, 32'hFFFFF801, 1'b0, 1'b1}, // R7 R8
    {8'h30, 3'd1, 32'h00000000, 8'h30, 3'd4, 32'hFFFFF800, 1'b0, 1'b1}, // R7
    {8'h08, 3'd4, 32'hFFFFFFFF, 8'h08, 3'd4, 32'h02000001, 1'b0, 1'b0}, // R10
    {8'h6A, 3'd1, 32'h00000000, 8'h68, 3'd4, 32'h00010000, 1'b0, 1'b0}, // R10
    {8'h22, 3'd2, 32'h00001234, 8'h20, 3'd4, 32'h1234C0FD, 1'b1, 1'b0}, // R5
    {8'hFF, 3'd2, 32'h0000BEEF, 8'hFE, 3'd4, {VID, 16'h0000}, 1'b0, 1'b0}, // R2 wrap
    {8'h0C, 3'd2, 32'h0000FFFF, 8'h0C, 3'd2, 32'h00002000, 1'b0, 1'b0}  // R10
  };

  task automatic chk(input string req_tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [2:0] l, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; len = l; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [2:0] l);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; len = l;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "rdata", rdata, 32'h0);
    chk("R1", "io_base", io_base, 32'h0);
    chk("R1", "rom_base", rom_base, 32'h0);
    chk("R1", "rom_en", {31'd0, rom_en}, 32'h0);
    chk("R1", "pulses", {30'd0, io_chg, rom_chg}, 32'h0);
    do_read(8'h00, 3'd4); chk("R1", "id", rdata, {DID, VID});
    do_read(8'h04, 3'd4); chk("R1", "cmd", rdata, 32'h00000001);
    do_read(8'h08, 3'd4); chk("R1", "class", rdata, 32'h02000001);
    do_read(8'h0C, 3'd4); chk("R1", "latency", rdata, 32'h00002000);
    do_read(8'h20, 3'd4); chk("R1", "iobar", rdata, 32'h00000001);
    do_read(8'h30, 3'd4); chk("R1", "rombar", rdata, 32'h00000000);
    do_read(8'h3C, 3'd4); chk("R1", "irq", rdata, 32'h00000100);
    do_read(8'h68, 3'd4); chk("R1", "clk", rdata, 32'h00010000);
    do_read(8'hC0, 3'd4); chk("R1", "route", rdata, 32'h00002000);

    // Vector table: write, check pulses, read back
    for (int i = 0; i < NVEC; i++) begin
      logic [87:0] v;
      v = VEC[i];
      do_write(v[87:80], v[79:77], v[76:45]);
      chk("R5", $sformatf("vec%0d io_chg", i), {31'd0, io_chg}, {31'd0, v[1]});
      chk("R7", $sformatf("vec%0d rom_chg", i), {31'd0, rom_chg}, {31'd0, v[0]});
      @(negedge clk);
      chk("R5", $sformatf("vec%0d pulse clear", i), {30'd0, io_chg, rom_chg}, 32'h0);
      do_read(v[44:37], v[36:34]);
      chk("R2", $sformatf("vec%0d rdata", i), rdata, v[33:2]);
    end

    // R5 exported I/O base, R8 exported ROM base
    chk("R5", "io_base_o", io_base, 32'h1234C0FC);
    chk("R8", "rom_base_o", rom_base, 32'hFFFFF800);
    chk("R7", "rom_en_o off", {31'd0, rom_en}, 32'h0);

    // R7 enable bit
    do_write(8'h30, 3'd1, 32'h000000FF);
    chk("R7", "rom_chg enable", {31'd0, rom_chg}, 32'h1);
    chk("R7", "rom_en_o on", {31'd0, rom_en}, 32'h1);

    // R2 short reads: upper bytes zero, rdata holds without request
    do_read(8'h21, 3'd1); chk("R2", "len1", rdata, 32'h000000C0);
    do_read(8'h22, 3'd2); chk("R2", "len2", rdata, 32'h00001234);
    repeat (2) @(negedge clk);
    chk("R2", "hold", rdata, 32'h00001234);

    // R9 no ROM instance
    chk("R9", "nr rom_en", {31'd0, rom_en_nr}, 32'h0);
    chk("R9", "nr rom_base", rom_base_nr, 32'h0);
    do_write(8'h30, 3'd4, 32'hFFFFFFFF);
    chk("R9", "nr rom_chg", {31'd0, rom_chg_nr}, 32'h0);
    do_read(8'h30, 3'd4);
    chk("R9", "nr rombar read", rdata_nr, 32'h0);
    chk("R5", "nr io_base", io_base_nr, 32'h1234C0FC);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule